// File: doc/BRIEF.md
# Security-Aware Tag Lookup Array

This block holds the tag side of a set-associative cache: one tag array per way, every entry carrying an address tag, a non-secure attribute, a valid flag and a parity bit. A lookup gives an index, a tag and the request's non-secure protection bit. All ways are read at once, and one cycle later the block reports whether any way hit, which way hit, whether more than one way matched, and which ways showed a parity error.

Security is part of the match. A line hits only when its stored non-secure attribute equals the request's bit. This means a secure copy and a non-secure copy of the same physical address live as separate lines. Nothing in the block clears lines when the processor changes security state.

An allocate port writes a fresh entry into a way chosen by the caller. An invalidate port drops the valid flag of one way at one index. The index width follows the way size. As ways grow beyond 16KB, the lowest tag bits become redundant with the index and are forced to zero.

Top module: `sec_tag_lookup`

## Requirements
- R1: After synchronous reset every entry of every way is invalid. No result is reported in the first cycle after reset, and a lookup to any index misses.
- R2: A result (`res_valid` high) appears exactly in the cycle after a cycle with `lk_valid` high, and in no other cycle.
- R3: A way hits when its entry at `lk_index` is valid, its stored tag equals `lk_tag` on the used bits, and its stored non-secure bit equals `lk_nonsec`. `res_way` gives the binary number of the hitting way.
- R4: A request with `lk_nonsec`=0 never hits a line allocated with `alloc_nonsec`=1, and the reverse also holds. Both copies of one tag can coexist in different ways of one index, and each is found by its own request type.
- R5: The lowest UNUSED_W = log2(WAY_SIZE_KB/16) bits of the 18-bit tag are treated as zero when an entry is stored and when it is compared. At the default 32KB way size, this is tag bit 0.
- R6: Each entry carries even parity over its tag, non-secure bit and valid bit. `alloc_par_flip` writes the inverted parity. On lookup, a valid entry with bad parity sets bit w of `res_parity_err` (bit w belongs to way w), and that way cannot hit.
- R7: When several ways hit, `res_way` is the lowest-numbered of them and `res_multi_hit` is 1. With a single hit, `res_multi_hit` is 0.
- R8: An allocation in the same cycle as a lookup to that index is not visible to that lookup. It is visible to the next one.
- R9: An invalidate clears only the valid flag of `inval_way` at `inval_index`. If an allocate and an invalidate target the same way and index in one cycle, the entry ends invalid.
- R10: On a miss, `res_hit`, `res_way` and `res_multi_hit` are 0. While `res_valid` is 0, all result outputs, including `res_parity_err`, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_index | input | INDEX_W | Lookup set index |
| lk_tag | input | 18 | Lookup address tag |
| lk_nonsec | input | 1 | Request protection non-secure bit |
| alloc_en | input | 1 | Write a new entry |
| alloc_way | input | WAY_W | Way to write |
| alloc_index | input | INDEX_W | Index to write |
| alloc_tag | input | 18 | Tag to store |
| alloc_nonsec | input | 1 | Non-secure attribute to store |
| alloc_par_flip | input | 1 | Store inverted parity (detector exercise) |
| inval_en | input | 1 | Clear a valid flag |
| inval_way | input | WAY_W | Way to invalidate |
| inval_index | input | INDEX_W | Index to invalidate |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Some way hit |
| res_way | output | WAY_W | Lowest hitting way |
| res_multi_hit | output | 1 | More than one way hit |
| res_parity_err | output | WAYS | Per-way parity error |

## Verification
On every cycle, the assertions check the following:
- the result timing relative to requests;
- that outputs stay quiet with no result;
- that a reported way really is the lowest matching way;
- that a way flagged with bad parity is never reported as the hit.

The scenarios show the parts that depend on what was written earlier:
- security separation between secure and non-secure copies;
- masking of the redundant tag bit;
- invisibility of a same-cycle allocation;
- invalidate precision and priority;
- the parity error being detected.

// File: rtl/sec_tag_pkg.sv
package sec_tag_pkg;

    localparam int TAG_FULL_W   = 18;
    localparam int BASE_INDEX_W = 9;

    typedef struct packed {
        logic [TAG_FULL_W-1:0] tag;
        logic                  ns;
    } tag_key_t;

    typedef struct packed {
        logic [TAG_FULL_W-1:0] tag;
        logic                  ns;
        logic                  par;
    } tag_entry_t;

    function automatic logic [TAG_FULL_W-1:0] mask_tag(
        input logic [TAG_FULL_W-1:0] t,
        input int                    unused_w
    );
        logic [TAG_FULL_W-1:0] m;
        for (int i = 0; i < TAG_FULL_W; i++) begin
            m[i] = (i >= unused_w) ? t[i] : 1'b0;
        end
        return m;
    endfunction

    // even parity bit covering tag, ns and a set valid flag
    function automatic logic gen_par(input tag_key_t k);
        return ^{k.tag, k.ns, 1'b1};
    endfunction

endpackage

// File: rtl/tag_way_bank.sv
module tag_way_bank
    import sec_tag_pkg::*;
#(
    parameter int INDEX_W   = 10,
    parameter int UNUSED_W  = 1,
    parameter bit PARITY_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [INDEX_W-1:0] rd_index,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_index,
    input  tag_key_t           wr_key,
    input  logic               wr_par_flip,
    input  logic               inv_en,
    input  logic [INDEX_W-1:0] inv_index,
    output tag_entry_t         rd_entry,
    output logic               rd_valid
);
    localparam int DEPTH = 1 << INDEX_W;

    tag_entry_t         mem [DEPTH];
    logic [DEPTH-1:0]   vld;
    tag_entry_t         wr_entry;
    tag_entry_t         rd_q;
    logic               rd_v_q;

    always_comb begin
        wr_entry.tag = mask_tag(wr_key.tag, UNUSED_W);
        wr_entry.ns  = wr_key.ns;
        wr_entry.par = PARITY_EN ? (gen_par('{tag: wr_entry.tag, ns: wr_key.ns}) ^ wr_par_flip)
                                 : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_index] <= wr_entry;
        end
    end

    // valid flags live in flops so reset and invalidate reach them directly
    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
        end else begin
            if (wr_en) begin
                vld[wr_index] <= 1'b1;
            end
            if (inv_en) begin
                vld[inv_index] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= mem[rd_index];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_v_q <= 1'b0;
        end else if (rd_en) begin
            rd_v_q <= vld[rd_index];
        end
    end

    assign rd_entry = rd_q;
    assign rd_valid = rd_v_q;

endmodule

// File: rtl/tag_way_compare.sv
module tag_way_compare
    import sec_tag_pkg::*;
#(
    parameter int UNUSED_W  = 1,
    parameter bit PARITY_EN = 1'b1
) (
    input  tag_entry_t entry,
    input  logic       valid,
    input  tag_key_t   key,
    output logic       hit,
    output logic       perr
);
    logic tag_eq;
    logic ns_eq;

    assign tag_eq = (mask_tag(entry.tag, UNUSED_W) == mask_tag(key.tag, UNUSED_W));
    assign ns_eq  = (entry.ns == key.ns);

    generate
        if (PARITY_EN) begin : g_par
            assign perr = valid && (^{entry.tag, entry.ns, 1'b1, entry.par});
        end else begin : g_nopar
            assign perr = 1'b0;
        end
    endgenerate

    assign hit = valid && tag_eq && ns_eq && !perr;

endmodule

// File: rtl/hit_resolve.sv
module hit_resolve #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]  hit_vec,
    output logic             any_hit,
    output logic [WAY_W-1:0] hit_way,
    output logic             multi
);
    int cnt;

    always_comb begin
        hit_way = '0;
        cnt     = 0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                hit_way = WAY_W'(w);
                cnt     = cnt + 1;
            end
        end
        any_hit = (cnt != 0);
        multi   = (cnt > 1);
    end

endmodule

// File: rtl/sec_tag_lookup.sv
module sec_tag_lookup
    import sec_tag_pkg::*;
#(
    parameter int WAYS        = 4,
    parameter int WAY_SIZE_KB = 32,
    parameter bit PARITY_EN   = 1'b1,
    localparam int INDEX_W    = BASE_INDEX_W + $clog2(WAY_SIZE_KB / 16),
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lk_valid,
    input  logic [INDEX_W-1:0]    lk_index,
    input  logic [TAG_FULL_W-1:0] lk_tag,
    input  logic                  lk_nonsec,
    input  logic                  alloc_en,
    input  logic [WAY_W-1:0]      alloc_way,
    input  logic [INDEX_W-1:0]    alloc_index,
    input  logic [TAG_FULL_W-1:0] alloc_tag,
    input  logic                  alloc_nonsec,
    input  logic                  alloc_par_flip,
    input  logic                  inval_en,
    input  logic [WAY_W-1:0]      inval_way,
    input  logic [INDEX_W-1:0]    inval_index,
    output logic                  res_valid,
    output logic                  res_hit,
    output logic [WAY_W-1:0]      res_way,
    output logic                  res_multi_hit,
    output logic [WAYS-1:0]       res_parity_err
);
    localparam int UNUSED_W = INDEX_W - BASE_INDEX_W;

    logic       req_q;
    tag_key_t   key_q;
    tag_key_t   wr_key;
    logic [WAYS-1:0] hit_vec;
    logic [WAYS-1:0] perr_vec;
    logic            any_hit;
    logic [WAY_W-1:0] hit_way;
    logic            multi;

    assign wr_key = '{tag: alloc_tag, ns: alloc_nonsec};

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            key_q <= '0;
        end else begin
            req_q <= lk_valid;
            if (lk_valid) begin
                key_q <= '{tag: mask_tag(lk_tag, UNUSED_W), ns: lk_nonsec};
            end
        end
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            tag_entry_t rd_entry;
            logic       rd_valid;

            tag_way_bank #(
                .INDEX_W   (INDEX_W),
                .UNUSED_W  (UNUSED_W),
                .PARITY_EN (PARITY_EN)
            ) u_bank (
                .clk         (clk),
                .rst         (rst),
                .rd_en       (lk_valid),
                .rd_index    (lk_index),
                .wr_en       (alloc_en && (alloc_way == WAY_W'(w))),
                .wr_index    (alloc_index),
                .wr_key      (wr_key),
                .wr_par_flip (alloc_par_flip),
                .inv_en      (inval_en && (inval_way == WAY_W'(w))),
                .inv_index   (inval_index),
                .rd_entry    (rd_entry),
                .rd_valid    (rd_valid)
            );

            tag_way_compare #(
                .UNUSED_W  (UNUSED_W),
                .PARITY_EN (PARITY_EN)
            ) u_cmp (
                .entry (rd_entry),
                .valid (rd_valid && req_q),
                .key   (key_q),
                .hit   (hit_vec[w]),
                .perr  (perr_vec[w])
            );
        end
    endgenerate

    hit_resolve #(
        .WAYS  (WAYS),
        .WAY_W (WAY_W)
    ) u_resolve (
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .hit_way (hit_way),
        .multi   (multi)
    );

    assign res_valid      = req_q;
    assign res_hit        = req_q && any_hit;
    assign res_way        = req_q ? hit_way : '0;
    assign res_multi_hit  = req_q && multi;
    assign res_parity_err = req_q ? perr_vec : '0;

endmodule

// File: rtl/sec_tag_lookup_chk.sv
module sec_tag_lookup_chk #(
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             lk_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [WAY_W-1:0] res_way,
    input logic             res_multi_hit,
    input logic [WAYS-1:0]  res_parity_err,
    input logic [WAYS-1:0]  hit_vec
);
    logic [WAYS-1:0] below_mask;
    assign below_mask = (WAYS'(1) << res_way) - WAYS'(1);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !res_valid); // R1

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> res_valid); // R2

    AST_RESULT_ONLY_REQ: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !res_valid); // R2

    AST_LOWEST_WAY: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (hit_vec[res_way] && ((hit_vec & below_mask) == '0))); // R7

    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        res_multi_hit |-> res_hit); // R7

    AST_PERR_BLOCKS_HIT: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> !res_parity_err[res_way]); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_hit && !res_multi_hit && res_parity_err == '0)); // R10

endmodule

bind sec_tag_lookup sec_tag_lookup_chk #(
    .WAYS  (WAYS),
    .WAY_W (WAY_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .lk_valid       (lk_valid),
    .res_valid      (res_valid),
    .res_hit        (res_hit),
    .res_way        (res_way),
    .res_multi_hit  (res_multi_hit),
    .res_parity_err (res_parity_err),
    .hit_vec        (hit_vec)
);

// File: tb/sec_tag_lookup_test.sv
module sec_tag_lookup_test;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 10;
    localparam int WW = 2;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lk_valid = 1'b0;
    logic [IW-1:0] lk_index = '0;
    logic [17:0]   lk_tag = '0;
    logic          lk_nonsec = 1'b0;
    logic          alloc_en = 1'b0;
    logic [WW-1:0] alloc_way = '0;
    logic [IW-1:0] alloc_index = '0;
    logic [17:0]   alloc_tag = '0;
    logic          alloc_nonsec = 1'b0;
    logic          alloc_par_flip = 1'b0;
    logic          inval_en = 1'b0;
    logic [WW-1:0] inval_way = '0;
    logic [IW-1:0] inval_index = '0;
    logic          res_valid, res_hit, res_multi_hit;
    logic [WW-1:0] res_way;
    logic [NW-1:0] res_parity_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sec_tag_lookup uut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_index(lk_index),
        .lk_tag(lk_tag), .lk_nonsec(lk_nonsec), .alloc_en(alloc_en),
        .alloc_way(alloc_way), .alloc_index(alloc_index), .alloc_tag(alloc_tag),
        .alloc_nonsec(alloc_nonsec), .alloc_par_flip(alloc_par_flip),
        .inval_en(inval_en), .inval_way(inval_way), .inval_index(inval_index),
        .res_valid(res_valid), .res_hit(res_hit), .res_way(res_way),
        .res_multi_hit(res_multi_hit), .res_parity_err(res_parity_err)
    );

    // {index, tag, ns, exp_hit, exp_way, exp_multi, exp_perr}
    localparam logic [36:0] VEC [0:8] = '{
        {10'd5,    18'h12345, 1'b0, 1'b1, 2'd0, 1'b0, 4'b0000}, // R3 R4 secure copy
        {10'd5,    18'h12345, 1'b1, 1'b1, 2'd1, 1'b0, 4'b0000}, // R4 non-secure copy
        {10'd5,    18'h12344, 1'b0, 1'b1, 2'd0, 1'b0, 4'b0000}, // R5 bit 0 ignored
        {10'd5,    18'h12347, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000}, // R3 bit 1 differs
        {10'd7,    18'h0ABCD, 1'b1, 1'b1, 2'd2, 1'b1, 4'b0000}, // R7 multi hit
        {10'd7,    18'h0ABCD, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000}, // R4 secure misses ns
        {10'd9,    18'h3FFFF, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0010}, // R6 parity
        {10'd1023, 18'h00002, 1'b0, 1'b1, 2'd2, 1'b0, 4'b0000}, // R3 top index
        {10'd6,    18'h12345, 1'b0, 1'b0, 2'd0, 1'b0, 4'b0000}  // R10 miss
    };

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic alloc(input logic [WW-1:0] w, input logic [IW-1:0] idx,
                         input logic [17:0] t, input logic ns, input logic flip);
        @(negedge clk);
        alloc_en = 1'b1; alloc_way = w; alloc_index = idx;
        alloc_tag = t; alloc_nonsec = ns; alloc_par_flip = flip;
        @(negedge clk);
        alloc_en = 1'b0; alloc_par_flip = 1'b0;
    endtask

    task automatic invalidate(input logic [WW-1:0] w, input logic [IW-1:0] idx);
        @(negedge clk);
        inval_en = 1'b1; inval_way = w; inval_index = idx;
        @(negedge clk);
        inval_en = 1'b0;
    endtask

    // result is sampled at the negedge following the capturing posedge
    task automatic lookup(input logic [IW-1:0] idx, input logic [17:0] t, input logic ns);
        @(negedge clk);
        lk_valid = 1'b1; lk_index = idx; lk_tag = t; lk_nonsec = ns;
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input logic h, input logic [WW-1:0] w,
                              input logic m, input logic [NW-1:0] p);
        check(req, "res_valid", 32'(res_valid), 32'(1'b1));
        check(req, "res_hit", 32'(res_hit), 32'(h));
        check(req, "res_way", 32'(res_way), 32'(w));
        check(req, "res_multi_hit", 32'(res_multi_hit), 32'(m));
        check(req, "res_parity_err", 32'(res_parity_err), 32'(p));
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", "res_valid after reset", 32'(res_valid), 32'(1'b0));
        lookup(10'd5, 18'h12345, 1'b0);
        expect_res("R1", 1'b0, 2'd0, 1'b0, 4'b0000);
        @(negedge clk);
        check("R2", "res_valid idle", 32'(res_valid), 32'(1'b0));
        check("R10", "res_parity_err idle", 32'(res_parity_err), 32'(0));

        alloc(2'd0, 10'd5,    18'h12345, 1'b0, 1'b0);
        alloc(2'd1, 10'd5,    18'h12345, 1'b1, 1'b0);
        alloc(2'd2, 10'd7,    18'h0ABCD, 1'b1, 1'b0);
        alloc(2'd3, 10'd7,    18'h0ABCD, 1'b1, 1'b0);
        alloc(2'd1, 10'd9,    18'h3FFFF, 1'b0, 1'b1);
        alloc(2'd2, 10'd1023, 18'h00002, 1'b0, 1'b0);

        for (int i = 0; i < 9; i++) begin
            logic [36:0] v;
            v = VEC[i];
            lookup(v[36:27], v[26:9], v[8]);
            expect_res($sformatf("R3/R4/R5/R6/R7 vec%0d", i), v[7], v[6:5], v[4], v[3:0]);
        end

        // R6: good copy in way 0 hits while way 1 reports bad parity
        alloc(2'd0, 10'd9, 18'h3FFFF, 1'b0, 1'b0);
        lookup(10'd9, 18'h3FFFF, 1'b0);
        expect_res("R6", 1'b1, 2'd0, 1'b0, 4'b0010);

        // R8: allocation and lookup in the same cycle
        @(negedge clk);
        alloc_en = 1'b1; alloc_way = 2'd3; alloc_index = 10'd20;
        alloc_tag = 18'h00F0F; alloc_nonsec = 1'b1;
        lk_valid = 1'b1; lk_index = 10'd20; lk_tag = 18'h00F0F; lk_nonsec = 1'b1;
        @(negedge clk);
        alloc_en = 1'b0; lk_valid = 1'b0;
        expect_res("R8 same cycle", 1'b0, 2'd0, 1'b0, 4'b0000);
        lookup(10'd20, 18'h00F0F, 1'b1);
        expect_res("R8 next", 1'b1, 2'd3, 1'b0, 4'b0000);

        // R9: invalidate way 0 index 5, way 1 copy untouched
        invalidate(2'd0, 10'd5);
        lookup(10'd5, 18'h12345, 1'b0);
        expect_res("R9 cleared", 1'b0, 2'd0, 1'b0, 4'b0000);
        lookup(10'd5, 18'h12345, 1'b1);
        expect_res("R9 other way", 1'b1, 2'd1, 1'b0, 4'b0000);

        // R9: invalidate wins over same-cycle allocate
        @(negedge clk);
        alloc_en = 1'b1; alloc_way = 2'd3; alloc_index = 10'd30;
        alloc_tag = 18'h2AAAA; alloc_nonsec = 1'b0;
        inval_en = 1'b1; inval_way = 2'd3; inval_index = 10'd30;
        @(negedge clk);
        alloc_en = 1'b0; inval_en = 1'b0;
        lookup(10'd30, 18'h2AAAA, 1'b0);
        expect_res("R9 priority", 1'b0, 2'd0, 1'b0, 4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule